// File: doc/BRIEF.md
# Dual-Stage Switch Open-Fault Detector

This block watches a cascaded pair of single-switch DC-DC converter stages that are driven in lockstep from one carrier. It receives a digitized inductor-current sample from each stage, the gate command of each stage's switch, and a strobe that marks the middle of the conducting interval. Once every switching period it checks that the inductor currents of both stages are climbing while the switches are meant to conduct. If either current is not climbing at that moment, one sticky fault flag is raised. The post-fault reconfiguration of such a converter pair is the same whichever stage failed, so the flag does not name the stage or the kind of fault.

Each current channel has a slope-sign extractor. It compares the newest sample with the sample taken four sample strobes earlier. The two signs are ANDed, and the two gate commands are ANDed. The edges of the combined gate give the period's turn-on and turn-off events. A five-state sequencer goes through each period in order: waiting for turn-on, early conduction, the on-check, late conduction, and the tripped state, which it never leaves. A switch that fails shorted goes unnoticed until its series fuse opens. From then on it behaves like an open switch and is caught by the same check.

Top module: `sw_fault_monitor`

## Requirements
- R1: A channel's slope sign becomes 1 when an accepted sample (sampleValid high) is greater than the sample accepted LAG=4 strobes before it, and becomes 0 when it is smaller. Samples are unsigned.
- R2: When the new sample equals the sample LAG strobes earlier, the channel keeps its previous sign.
- R3: After reset, a channel's sign stays 0 until LAG samples are held. It first updates with the (LAG+1)-th accepted sample.
- R4: The on-check passes only when both channel signs are 1. If either stage's current is not rising at the check, faultFlag is raised.
- R5: The period is timed from gateA AND gateB. A rising edge of that product is turn-on and a falling edge is turn-off. A period with both currents rising through the on-check never raises faultFlag. A gate pulse on one stage alone starts no period.
- R6: The on-check uses the sign as updated by the sample accepted in the same cycle as midStrobe. faultFlag is still 0 one cycle after that cycle and is 1 two cycles after it.
- R7: A failure that starts after the on-check of a period leaves faultFlag at 0 for that period and is flagged at the next period's on-check.
- R8: faultFlag stays at 1 until a synchronous reset (rst high at a clock edge). Reset returns the sequencer to waiting for turn-on and clears the flag.
- R9: Strobes out of sequence are ignored. A midStrobe while waiting for turn-on has no effect. A turn-off while waiting for midStrobe has no effect, so a later midStrobe still triggers the on-check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Both current samples are new this cycle |
| curA | input | SAMPLE_W | Inductor current sample, first stage (unsigned) |
| curB | input | SAMPLE_W | Inductor current sample, second stage (unsigned) |
| gateA | input | 1 | Gate command of first-stage switch |
| gateB | input | 1 | Gate command of second-stage switch |
| midStrobe | input | 1 | One-cycle pulse at the middle of the conducting interval |
| faultFlag | output | 1 | Sticky switch-fault indication |

## Verification
The sharpest overlap is a sign update and the on-check decision landing on the same edge. The sample that arrives together with midStrobe updates the sign at the edge where the sequencer enters the on-check, and the check then reads that fresh sign. The bench provokes this with a second-stage current that rises through the whole early conduction interval and drops sharply only in the midStrobe cycle. It judges the result cycle by cycle: the flag must be 0 one cycle later and 1 two cycles later. A second overlap is a turn-off edge arriving while the sequencer still waits for midStrobe. The bench drives a short gate pulse followed by a midStrobe during falling currents and expects a trip.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  // Sequencer states, one pass per switching period
  typedef enum logic [2:0] {
    ST_WAIT_ON  = 3'd0,
    ST_ON_EARLY = 3'd1,
    ST_ON_CHECK = 3'd2,
    ST_ON_LATE  = 3'd3,
    ST_TRIPPED  = 3'd4
  } ctl_state_e;

  // Events handed from the datapath to the sequencer
  typedef struct packed {
    logic turnOn;
    logic midOn;
    logic turnOff;
    logic slopeUp;
  } dp_strobes_t;

endpackage

// File: rtl/slope_sign.sv
module slope_sign #(
  parameter int W   = 12,
  parameter int LAG = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleValid,
  input  logic [W-1:0] sample,
  output logic         rising
);
  localparam int FILL_W = $clog2(LAG + 1);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(LAG);

  logic [W-1:0]      tapLine [LAG];
  logic [FILL_W-1:0] fill;
  logic              signQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAG; i++) tapLine[i] <= '0;
      fill  <= '0;
      signQ <= 1'b0;
    end else if (sampleValid) begin
      tapLine[0] <= sample;
      for (int i = 1; i < LAG; i++) tapLine[i] <= tapLine[i-1];
      if (fill != FULL) begin
        fill <= fill + 1'b1;
      end else begin
        // oldest tap holds the sample taken LAG strobes ago
        if (sample > tapLine[LAG-1])      signQ <= 1'b1;
        else if (sample < tapLine[LAG-1]) signQ <= 1'b0;
      end
    end
  end

  assign rising = signQ;

endmodule

// File: rtl/sfd_datapath.sv
module sfd_datapath
  import sfd_pkg::*;
#(
  parameter int W      = 12,
  parameter int LAG    = 4,
  parameter int STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sampleValid,
  input  logic [STAGES-1:0][W-1:0]     samples,
  input  logic [STAGES-1:0]            gates,
  input  logic                         midStrobe,
  output dp_strobes_t                  strobes
);
  logic [STAGES-1:0] chanSign;
  logic              gateAll;
  logic              gatePrev;

  for (genvar s = 0; s < STAGES; s++) begin : g_chan
    slope_sign #(.W(W), .LAG(LAG)) u_sign (
      .clk        (clk),
      .rst        (rst),
      .sampleValid(sampleValid),
      .sample     (samples[s]),
      .rising     (chanSign[s])
    );
  end

  assign gateAll = &gates;

  always_ff @(posedge clk) begin
    if (rst) gatePrev <= 1'b0;
    else     gatePrev <= gateAll;
  end

  always_comb begin
    strobes.turnOn  = gateAll & ~gatePrev;
    strobes.turnOff = ~gateAll & gatePrev;
    strobes.midOn   = midStrobe;
    strobes.slopeUp = &chanSign;
  end

endmodule

// File: rtl/sfd_control.sv
module sfd_control
  import sfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dp_strobes_t strobes,
  output logic        faultFlag
);
  ctl_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WAIT_ON:  if (strobes.turnOn)  stateNext = ST_ON_EARLY;
      ST_ON_EARLY: if (strobes.midOn)   stateNext = ST_ON_CHECK;
      ST_ON_CHECK: stateNext = strobes.slopeUp ? ST_ON_LATE : ST_TRIPPED;
      ST_ON_LATE:  if (strobes.turnOff) stateNext = ST_WAIT_ON;
      ST_TRIPPED:  stateNext = ST_TRIPPED;
      default:     stateNext = ST_WAIT_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT_ON;
    else     state <= stateNext;
  end

  assign faultFlag = (state == ST_TRIPPED);

endmodule

// File: rtl/sw_fault_monitor.sv
module sw_fault_monitor
  import sfd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LAG      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] curA,
  input  logic [SAMPLE_W-1:0] curB,
  input  logic                gateA,
  input  logic                gateB,
  input  logic                midStrobe,
  output logic                faultFlag
);
  localparam int STAGES = 2;

  logic [STAGES-1:0][SAMPLE_W-1:0] samples;
  logic [STAGES-1:0]               gates;
  dp_strobes_t                     dpStrobes;

  assign samples[0] = curA;
  assign samples[1] = curB;
  assign gates      = {gateB, gateA};

  sfd_datapath #(.W(SAMPLE_W), .LAG(LAG), .STAGES(STAGES)) u_data (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .samples    (samples),
    .gates      (gates),
    .midStrobe  (midStrobe),
    .strobes    (dpStrobes)
  );

  sfd_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .strobes  (dpStrobes),
    .faultFlag(faultFlag)
  );

endmodule

// File: rtl/sw_fault_monitor_chk.sv
module sw_fault_monitor_chk #(
  parameter int LAG = 4
) (
  input logic clk,
  input logic rst,
  input logic sampleValid,
  input logic midStrobe,
  input logic slopeUp,
  input logic faultFlag
);
  localparam int CNT_W = $clog2(LAG + 2);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LAG + 1);
  localparam logic [CNT_W-1:0] CNT_LAG = CNT_W'(LAG);

  logic [CNT_W-1:0] validSeen;

  always_ff @(posedge clk) begin
    if (rst) validSeen <= '0;
    else if (sampleValid && validSeen != CNT_TOP) validSeen <= validSeen + 1'b1;
  end

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (rst)
    faultFlag |=> faultFlag); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !faultFlag); // R8

  AST_TRIP_AFTER_MID: assert property (@(posedge clk) disable iff (rst)
    $rose(faultFlag) |-> $past(midStrobe, 2)); // R6

  AST_TRIP_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(faultFlag) |-> !$past(slopeUp)); // R4

  AST_SIGN_QUIET_START: assert property (@(posedge clk) disable iff (rst)
    (validSeen <= CNT_LAG) |-> !slopeUp); // R3

endmodule

bind sw_fault_monitor sw_fault_monitor_chk #(.LAG(LAG)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sampleValid(sampleValid),
  .midStrobe  (midStrobe),
  .slopeUp    (dpStrobes.slopeUp),
  .faultFlag  (faultFlag)
);

// File: tb/sw_fault_monitor_test.sv
module sw_fault_monitor_test;
  localparam int W      = 12;
  localparam int ON_LEN = 12;
  localparam int OFF_LEN = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst, sampleValid, gateA, gateB, midStrobe, faultFlag;
  logic [W-1:0] curA, curB;
  int           valA, valB;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;
  exp_t q[$];

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  sw_fault_monitor #(.SAMPLE_W(W), .LAG(4)) uut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .curA(curA), .curB(curB), .gateA(gateA), .gateB(gateB),
    .midStrobe(midStrobe), .faultFlag(faultFlag)
  );

  // Monitor: compares the flag just after each falling edge
  always @(negedge clk) begin
    exp_t it;
    #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      compared++;
      if (faultFlag !== it.exp) begin
        mismatched++;
        $display("FAIL %s: faultFlag=%0b expected %0b", it.tag, faultFlag, it.exp);
      end
    end
  end

  task automatic pushExp(input logic e, input string tag);
    exp_t it;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(input int dA, input int dB, input bit gA, input bit gB,
                      input bit m, input bit v);
    @(negedge clk);
    valA = valA + dA;
    valB = valB + dB;
    curA = valA[W-1:0];
    curB = valB[W-1:0];
    gateA = gA;
    gateB = gB;
    midStrobe = m;
    sampleValid = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(-1, -1, 0, 0, 0, 1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; sampleValid = 1'b0; gateA = 1'b0; gateB = 1'b0; midStrobe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    pushExp(1'b0, "R8 reset returns to idle and clears flag");
  endtask

  // One synchronous switching period
  task automatic period(input int midAt, input int dA, input int dB, input int dBMid,
                        input int flatFrom, input int dAlate, input int dBlate,
                        input logic exp, input string tag, input bit timed);
    for (int c = 0; c < ON_LEN; c++) begin
      int a, b;
      if (c < midAt) begin
        a = (c >= flatFrom) ? 0 : dA;
        b = (c >= flatFrom) ? 0 : dB;
      end else if (c == midAt) begin
        a = (c >= flatFrom) ? 0 : dA;
        b = dBMid;
      end else begin
        a = dAlate;
        b = dBlate;
      end
      step(a, b, 1, 1, c == midAt, 1);
      if (timed && c == midAt + 1) pushExp(1'b0, "R6 flag low one cycle after mid-strobe cycle");
      if (timed && c == midAt + 2) pushExp(1'b1, "R6 flag high two cycles after mid-strobe cycle");
    end
    for (int c = 0; c < OFF_LEN; c++) step(-1, -1, 0, 0, 0, 1);
    pushExp(exp, tag);
  endtask

  initial begin
    rst = 1'b1; sampleValid = 1'b0; gateA = 1'b0; gateB = 1'b0; midStrobe = 1'b0;
    valA = 2000; valB = 2000;
    curA = valA[W-1:0]; curB = valB[W-1:0];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pushExp(1'b0, "R8 reset state flag low");
    idle(8);

    period(6, 1, 1, 1, 99, 1, 1, 1'b0, "R1 R5 healthy period one", 0);
    period(6, 1, 1, 1, 99, 1, 1, 1'b0, "R1 R5 healthy period two", 0);
    period(10, 1, 1, 0, 5, 1, 1, 1'b0, "R2 flat current keeps rising sign", 0);

    // R9: mid-strobe while waiting for turn-on, currents falling
    step(-1, -1, 0, 0, 1, 1);
    idle(4);
    pushExp(1'b0, "R9 mid-strobe in wait state ignored");

    // R5: only stage A gated, currents falling, mid-strobe given
    for (int c = 0; c < ON_LEN; c++) step(-1, -1, 1, 0, c == 6, 1);
    idle(OFF_LEN);
    pushExp(1'b0, "R5 single-stage gate pulse starts no period");

    period(6, -1, 1, 1, 99, -1, 1, 1'b1, "R4 R1 stage A open flagged", 0);
    period(6, 1, 1, 1, 99, 1, 1, 1'b1, "R8 flag sticky through healthy period", 0);

    doReset();
    idle(8);
    period(6, 1, -1, -1, 99, 1, -1, 1'b1, "R4 stage B open flagged", 0);

    doReset();
    idle(8);
    period(6, 1, 1, 1, 99, 1, -1, 1'b0, "R7 failure after check not yet flagged", 0);
    period(6, 1, -1, -1, 99, 1, -1, 1'b1, "R7 failure flagged at next period check", 0);

    doReset();
    idle(8);
    period(6, 1, 1, -10, 99, 1, 1, 1'b1, "R6 drop with mid-strobe trips", 1);

    // R9: turn-off while waiting for mid-strobe, mid-strobe later in off time
    doReset();
    idle(8);
    for (int c = 0; c < 3; c++) step(1, 1, 1, 1, 0, 1);
    for (int c = 0; c < OFF_LEN; c++) step(-1, -1, 0, 0, c == 6, 1);
    idle(2);
    pushExp(1'b1, "R9 early turn-off ignored, later mid-strobe checks");

    // R3: fifth sample after reset produces a valid rising sign
    doReset();
    for (int c = 0; c < ON_LEN; c++) step(1, 1, 1, 1, c == 4, 1);
    idle(OFF_LEN);
    pushExp(1'b0, "R3 fifth sample enables sign, no trip");

    // R3: only three samples held at the check, sign still zero
    doReset();
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    for (int c = 0; c < ON_LEN; c++) step(1, 1, 1, 1, c == 2, 1);
    idle(OFF_LEN);
    pushExp(1'b1, "R3 sign zero before four samples held, check trips");

    idle(4);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (all requirements): run not finished, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule